// File: doc/BRIEF.md
# Local-Storage Pixel Sensor Timing Sequencer

This block drives the control strobes of a pixel sensor in which every pixel keeps a short chain of charge samples on the chip. A collision train lasts about one millisecond. During the train the sequencer moves the collected charge from the photogate into the pixel's storage chain at a steady, fixed pace. The number of moves equals the depth of the chain, so no sample is overwritten. The quiet gap that follows the train lasts about 200 ms, and all conversion happens there. The sequencer walks the sensor one row at a time at a slow pace, and all columns are read in parallel.

A single-cycle trigger starts a run. Two parameterised dividers derive the capture pace and the readout pace from the system clock. With the defaults (100 MHz clock, 5000 and 100 cycles) this gives 20 moves at 20 kHz and a 1 MHz readout step. For each stored sample of the selected row, readout issues four steps in this order: a reset of the output node, a strobe for the reset level, a shift of one stored charge onto the output gate, and a strobe for the signal level. A one-cycle done pulse marks the end of the run. A trigger that arrives while a run is in progress is dropped and sets a sticky overrun flag.

Top module: `insitu_seq`

## Requirements
- R1: After reset, every strobe, every row-select bit, busy_o, done_o and ovr_o are low. They stay low while idle with no trigger.
- R2: A trigger sampled while idle raises busy_o in the next cycle, with xfer_o high in that same cycle. Exactly NUM_SLOTS one-cycle transfer pulses follow, spaced CAPT_DIV cycles apart, and the capture phase lasts NUM_SLOTS*CAPT_DIV cycles.
- R3: During capture, shift_o pulses for one cycle exactly one cycle after each transfer pulse, and is otherwise low.
- R4: Readout begins in the cycle after capture ends. For every sample it runs four steps of READ_DIV cycles each, in the fixed order output reset (prst_o), reset-level strobe (smp_rst_o), storage shift (shift_o), signal-level strobe (smp_sig_o). Each strobe is high only in the first cycle of its step.
- R5: rsel_o is one-hot during readout and zero otherwise. Row index r drives bit r. Rows are served in ascending order from bit 0, and each row is held for its NUM_SLOTS samples.
- R6: In the cycle after the last row's last signal strobe, done_o is high for one cycle and busy_o is low.
- R7: A trigger sampled while busy leaves the running sequence unchanged and sets ovr_o. ovr_o stays set until reset.
- R8: At most one of xfer_o, shift_o, prst_o, smp_rst_o and smp_sig_o is high in any cycle.
- R9: Asserting reset in the middle of a run returns every output to the R1 state, and clears ovr_o. A following trigger starts a fresh run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Train-start trigger, one-cycle pulse |
| xfer_o | output | 1 | Photogate-to-storage transfer strobe |
| shift_o | output | 1 | Storage chain shift clock (capture and readout) |
| rsel_o | output | NUM_ROWS | One-hot row select |
| prst_o | output | 1 | Output node reset strobe |
| smp_rst_o | output | 1 | Reset-level sample strobe |
| smp_sig_o | output | 1 | Signal-level sample strobe |
| busy_o | output | 1 | Capture or readout in progress |
| done_o | output | 1 | One-cycle end-of-readout pulse |
| ovr_o | output | 1 | Sticky flag for a trigger dropped while busy |

## Verification
The bench builds the block with NUM_ROWS=3, NUM_SLOTS=4, CAPT_DIV=8 and READ_DIV=2. With these values a full capture-and-readout run takes about 130 cycles, so every output can be compared against a timeline model on every cycle of every run. Three rows exercise the row-to-row handover and the final row. A step length of two leaves a hold cycle between strobes, which exposes any strobe that lasts longer than one cycle. The short run also leaves room to repeat the run with a trigger dropped during capture and with a reset in the middle of readout.

// File: rtl/isq_pkg.sv
package isq_pkg;

    // Top-level phase of the sequencer
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CAPT = 2'd1,
        PH_READ = 2'd2
    } phase_e;

    // Per-sample readout step; the order is the order of issue
    typedef enum logic [1:0] {
        ST_RST   = 2'd0,
        ST_SRST  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_SSIG  = 2'd3
    } step_e;

endpackage

// File: rtl/isq_pace.sv
// Restartable modulo-DIV pace counter; the caller decodes its phase.
module isq_pace #(
    parameter int DIV = 4,
    localparam int W = $clog2(DIV > 1 ? DIV : 2)
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         en_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (en_i) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = (cnt_q == LAST);
endmodule

// File: rtl/isq_row_dec.sv
// Gated binary-to-one-hot row decoder.
module isq_row_dec #(
    parameter int N = 16,
    localparam int W = $clog2(N > 1 ? N : 2)
) (
    input  logic         en_i,
    input  logic [W-1:0] idx_i,
    output logic [N-1:0] sel_o
);
    for (genvar g = 0; g < N; g++) begin : g_row
        assign sel_o[g] = en_i && (idx_i == W'(g));
    end
endmodule

// File: rtl/insitu_seq.sv
module insitu_seq
    import isq_pkg::*;
#(
    parameter int NUM_ROWS  = 16,
    parameter int NUM_SLOTS = 20,
    parameter int CAPT_DIV  = 5000,
    parameter int READ_DIV  = 100
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                trig_i,
    output logic                xfer_o,
    output logic                shift_o,
    output logic [NUM_ROWS-1:0] rsel_o,
    output logic                prst_o,
    output logic                smp_rst_o,
    output logic                smp_sig_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                ovr_o
);
    localparam int RW = $clog2(NUM_ROWS > 1 ? NUM_ROWS : 2);
    localparam int SW = $clog2(NUM_SLOTS > 1 ? NUM_SLOTS : 2);
    localparam int CW = $clog2(CAPT_DIV > 1 ? CAPT_DIV : 2);
    localparam int DW = $clog2(READ_DIV > 1 ? READ_DIV : 2);

    localparam logic [SW-1:0] SLOT_LAST = SW'(NUM_SLOTS - 1);
    localparam logic [RW-1:0] ROW_LAST  = RW'(NUM_ROWS - 1);
    localparam logic [CW-1:0] CAP_XFER  = '0;
    localparam logic [CW-1:0] CAP_SHIFT = CW'(1);

    typedef struct packed {
        phase_e        ph;
        step_e         st;
        logic [SW-1:0] slot;   // capture slot index
        logic [SW-1:0] smp;    // readout sample index within a row
        logic [RW-1:0] row;    // readout row index
        logic          done;
        logic          ovr;
    } seq_t;

    seq_t s_d, s_q;

    logic          cap_clr, cap_wrap;
    logic [CW-1:0] cap_cnt;
    logic          rd_clr, rd_wrap, rd_first;
    logic [DW-1:0] rd_cnt;
    logic          in_capt, in_read;

    assign in_capt  = (s_q.ph == PH_CAPT);
    assign in_read  = (s_q.ph == PH_READ);
    assign rd_first = (rd_cnt == '0);

    isq_pace #(.DIV(CAPT_DIV)) u_cap_pace (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (cap_clr),
        .en_i   (in_capt),
        .cnt_o  (cap_cnt),
        .wrap_o (cap_wrap)
    );

    isq_pace #(.DIV(READ_DIV)) u_rd_pace (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (rd_clr),
        .en_i   (in_read),
        .cnt_o  (rd_cnt),
        .wrap_o (rd_wrap)
    );

    isq_row_dec #(.N(NUM_ROWS)) u_row_dec (
        .en_i  (in_read),
        .idx_i (s_q.row),
        .sel_o (rsel_o)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        cap_clr  = 1'b0;
        rd_clr   = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (trig_i) begin
                    s_d.ph   = PH_CAPT;
                    s_d.slot = '0;
                    cap_clr  = 1'b1;
                end
            end
            PH_CAPT: begin
                if (trig_i) begin
                    s_d.ovr = 1'b1;
                end
                if (cap_wrap) begin
                    if (s_q.slot == SLOT_LAST) begin
                        s_d.ph  = PH_READ;
                        s_d.st  = ST_RST;
                        s_d.smp = '0;
                        s_d.row = '0;
                        rd_clr  = 1'b1;
                    end else begin
                        s_d.slot = s_q.slot + 1'b1;
                    end
                end
            end
            PH_READ: begin
                if (trig_i) begin
                    s_d.ovr = 1'b1;
                end
                if (rd_first && s_q.st == ST_SSIG &&
                    s_q.smp == SLOT_LAST && s_q.row == ROW_LAST) begin
                    // final signal strobe is issued this cycle
                    s_d.ph   = PH_IDLE;
                    s_d.done = 1'b1;
                end else if (rd_wrap) begin
                    if (s_q.st == ST_SSIG) begin
                        s_d.st = ST_RST;
                        if (s_q.smp == SLOT_LAST) begin
                            s_d.smp = '0;
                            s_d.row = s_q.row + 1'b1;
                        end else begin
                            s_d.smp = s_q.smp + 1'b1;
                        end
                    end else begin
                        s_d.st = step_e'(s_q.st + 2'd1);
                    end
                end
            end
            default: begin
                s_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign xfer_o    = in_capt && (cap_cnt == CAP_XFER);
    assign shift_o   = (in_capt && (cap_cnt == CAP_SHIFT)) ||
                       (in_read && rd_first && s_q.st == ST_SHIFT);
    assign prst_o    = in_read && rd_first && (s_q.st == ST_RST);
    assign smp_rst_o = in_read && rd_first && (s_q.st == ST_SRST);
    assign smp_sig_o = in_read && rd_first && (s_q.st == ST_SSIG);
    assign busy_o    = (s_q.ph != PH_IDLE);
    assign done_o    = s_q.done;
    assign ovr_o     = s_q.ovr;
endmodule

// File: rtl/insitu_seq_chk.sv
module insitu_seq_chk #(
    parameter int NUM_ROWS = 16
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                trig_i,
    input logic                xfer_o,
    input logic                shift_o,
    input logic [NUM_ROWS-1:0] rsel_o,
    input logic                prst_o,
    input logic                smp_rst_o,
    input logic                smp_sig_o,
    input logic                busy_o,
    input logic                done_o,
    input logic                ovr_o
);
    logic [4:0] strobes;
    assign strobes = {xfer_o, shift_o, prst_o, smp_rst_o, smp_sig_o};

    assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (strobes == '0 && rsel_o == '0));

    assert_start_xfer_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && trig_i) |=> (busy_o && xfer_o));

    assert_shift_follows_xfer_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xfer_o |=> (shift_o && rsel_o == '0));

    assert_rows_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(rsel_o));

    assert_no_row_in_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xfer_o |-> (rsel_o == '0));

    assert_row_at_sample_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (smp_sig_o || smp_rst_o || prst_o) |-> ($countones(rsel_o) == 1));

    assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_done_not_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && $past(smp_sig_o)));

    assert_ovr_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovr_o |=> ovr_o);

    assert_ovr_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ovr_o) |-> $past(trig_i && busy_o));

    assert_single_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(strobes) <= 1);
endmodule

bind insitu_seq insitu_seq_chk #(.NUM_ROWS(NUM_ROWS)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig_i),
    .xfer_o    (xfer_o),
    .shift_o   (shift_o),
    .rsel_o    (rsel_o),
    .prst_o    (prst_o),
    .smp_rst_o (smp_rst_o),
    .smp_sig_o (smp_sig_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .ovr_o     (ovr_o)
);

// File: tb/insitu_seq_bench.sv
`timescale 1ns/1ps
module insitu_seq_bench;
    localparam int NR  = 3;
    localparam int NS  = 4;
    localparam int CD  = 8;
    localparam int RD  = 2;
    localparam int R0  = NS * CD + 1;
    localparam int FIN = R0 + (NR * NS * 4 - 1) * RD;
    localparam int NTAB = 16;

    // vector bits: [9]done [8]busy [7]sig [6]srst [5]shift [4]prst [3]xfer [2:0]rows
    localparam int TAB_T [NTAB] = '{1, 2, 3, 9, 25, 32, 33, 34, 35, 37, 39, 41, 65, 97, 127, 128};
    localparam logic [9:0] TAB_V [NTAB] = '{
        10'b0100001000, 10'b0100100000, 10'b0100000000, 10'b0100001000,
        10'b0100001000, 10'b0100000000, 10'b0100010001, 10'b0100000001,
        10'b0101000001, 10'b0100100001, 10'b0110000001, 10'b0100010001,
        10'b0100010010, 10'b0100010100, 10'b0110000100, 10'b1000000000};
    localparam int TAB_R [NTAB] = '{2, 3, 2, 2, 2, 2, 4, 4, 4, 4, 4, 4, 5, 5, 4, 6};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig = 1'b0;
    logic xfer, shift, prst, srst, ssig, busy, done, ovr;
    logic [NR-1:0] rsel;
    int errs = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    insitu_seq #(.NUM_ROWS(NR), .NUM_SLOTS(NS), .CAPT_DIV(CD), .READ_DIV(RD)) u_insitu_seq (
        .clk_i(clk), .rst_ni(rst_n), .trig_i(trig),
        .xfer_o(xfer), .shift_o(shift), .rsel_o(rsel), .prst_o(prst),
        .smp_rst_o(srst), .smp_sig_o(ssig), .busy_o(busy), .done_o(done), .ovr_o(ovr));

    function automatic logic [9:0] obs();
        return {done, busy, ssig, srst, shift, prst, xfer, rsel};
    endfunction

    // Timeline model from R2..R6; t counts cycles after the trigger edge
    function automatic logic [9:0] expv(int t);
        logic [9:0] v;
        int k, u, q, row, s;
        v = '0;
        if (t >= 1 && t <= NS * CD) begin
            k = (t - 1) % CD;
            v[8] = 1'b1;
            v[3] = (k == 0);
            v[5] = (k == 1);
        end else if (t >= R0 && t <= FIN) begin
            u = t - R0;
            q = u / RD;
            row = q / (NS * 4);
            s = q % 4;
            v[8] = 1'b1;
            v[2:0] = 3'(1 << row);
            if (u % RD == 0) begin
                case (s)
                    0: v[4] = 1'b1;
                    1: v[6] = 1'b1;
                    2: v[5] = 1'b1;
                    default: v[7] = 1'b1;
                endcase
            end
        end else if (t == FIN + 1) begin
            v[9] = 1'b1;
        end
        return v;
    endfunction

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Full run: trigger, compare every cycle; optional table walk and stray trigger
    task automatic run_seq(input bit use_tab, input int ovr_at);
        logic [9:0] o;
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
        for (int t = 1; t <= FIN + 3; t++) begin
            o = obs();
            if (t <= NS * CD)      chk($sformatf("R2 R3 capture t=%0d", t), o, expv(t));
            else if (t <= FIN)     chk($sformatf("R4 R5 readout t=%0d", t), o, expv(t));
            else                   chk($sformatf("R6 done/idle t=%0d", t), o, expv(t));
            checks++;
            if ($countones(o[7:3]) > 1) begin
                errs++;
                $display("FAIL R8 t=%0d: got %0d strobes expected at most 1", t, $countones(o[7:3]));
            end
            if (use_tab) begin
                for (int i = 0; i < NTAB; i++) begin
                    if (TAB_T[i] == t)
                        chk($sformatf("R%0d table t=%0d", TAB_R[i], t), o, TAB_V[i]);
                end
            end
            trig = (t == ovr_at);
            @(negedge clk);
        end
        trig = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1: reset state and quiet idle
        chk("R1 reset outputs", obs(), '0);
        chk("R1 reset overrun", {9'b0, ovr}, '0);
        repeat (5) @(negedge clk);
        chk("R1 idle without trigger", obs(), '0);

        // Plain run, table walk
        run_seq(1'b1, 0);
        chk("R7 no overrun on clean run", {9'b0, ovr}, '0);

        // R7: stray trigger during capture leaves the timeline unchanged
        run_seq(1'b0, 10);
        chk("R7 overrun flag set", {9'b0, ovr}, 10'd1);
        repeat (4) @(negedge clk);
        chk("R7 overrun flag sticky", {9'b0, ovr}, 10'd1);

        // R9: reset in the middle of readout, then a fresh run
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
        repeat (45) @(negedge clk);
        chk("R9 busy before reset", {9'b0, busy}, 10'd1);
        do_reset();
        chk("R9 outputs after mid-run reset", obs(), '0);
        chk("R9 overrun cleared by reset", {9'b0, ovr}, '0);
        run_seq(1'b0, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule